// File: doc/BRIEF.md
# Horizontal Chroma 4:4:4 to 4:2:2 Downsampler

This block accepts a YCbCr stream with full-resolution chroma, one pixel per clock, and produces a stream in which every luma sample survives but only one Cb/Cr pair remains for each two adjacent pixels. The output has a luma lane and a single chroma lane. The chroma lane carries the pair's Cb beside the even pixel of the pair and its Cr beside the odd pixel. Line boundaries are marked on the input by a start flag and an end flag. The flags travel with the pixels to the output.

Two static configuration bits select one of four horizontal chroma filters. The first bit switches the low-pass filter on. The second bit puts the output chroma halfway between the two luma samples of the pair instead of on top of the even one. Taps that would fall outside the current line repeat the nearest sample at the line edge. The weighted sum is rounded to nearest and clipped to the sample width. Cb and Cr go through identical but separate filters.

Usage condition: the pixels of a line arrive on consecutive cycles, from the start flag to the end flag. Idle cycles are allowed only between lines, and the next line may begin on the cycle right after the end of the last one. The configuration bits change only while no line is in flight.

Top module: `c422_downsampler`

## Requirements
- R1: Each input pixel appears on the output exactly 4 clock cycles after it is presented, with `out_y`, `out_sol` and `out_eol` equal to the input luma and line flags, and `out_valid` high only for those cycles. After reset, `out_valid` and `out_c_valid` are 0.
- R2: Pixel positions are counted from 0 at the start flag. For each pair (2k, 2k+1), the output of pixel 2k carries the pair's Cb with `out_c_is_cr`=0, and the output of pixel 2k+1 carries the pair's Cr with `out_c_is_cr`=1. Both have `out_c_valid`=1.
- R3: The mode number is {`cfg_lpf_en`, `cfg_pos_ctr`}. Mode 0 (both bits 0) outputs chroma c[2k] unfiltered, cosited with the even luma sample.
- R4: Mode 1 (`cfg_lpf_en`=0, `cfg_pos_ctr`=1) outputs (c[2k]+c[2k+1]+1)>>1, centred between the two luma samples.
- R5: Mode 2 (`cfg_lpf_en`=1, `cfg_pos_ctr`=0) outputs (c[2k-1]+2c[2k]+c[2k+1]+2)>>2, cosited.
- R6: Mode 3 (both bits 1) outputs (c[2k-1]+3c[2k]+3c[2k+1]+c[2k+2]+4)>>3, centred. Results above 255 are clipped to 255.
- R7: A tap before the first pixel of a line uses pixel 0, and a tap after the last pixel N-1 uses pixel N-1.
- R8: When a line has an odd pixel count, its last pixel is output with `out_c_valid`=0, `out_c`=0 and `out_c_is_cr`=0. Its luma is still delivered.
- R9: Cb is computed only from Cb samples and Cr only from Cr samples, using the same taps and the same rounding.
- R10: When a line starts on the cycle right after the previous line ends, no filter tap takes a sample from the other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lpf_en | input | 1 | Low-pass enable (mode bit 1) |
| cfg_pos_ctr | input | 1 | 1 = centred chroma, 0 = cosited (mode bit 0) |
| in_valid | input | 1 | Input pixel present |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| in_y | input | DW | Input luma |
| in_cb | input | DW | Input Cb |
| in_cr | input | DW | Input Cr |
| out_valid | output | 1 | Output pixel present |
| out_sol | output | 1 | First output pixel of a line |
| out_eol | output | 1 | Last output pixel of a line |
| out_y | output | DW | Output luma |
| out_c | output | DW | Interleaved chroma (Cb then Cr) |
| out_c_valid | output | 1 | Chroma lane carries a sample |
| out_c_is_cr | output | 1 | Chroma lane holds Cr (1) or Cb (0) |

## Verification
The bound checker watches, on every cycle, the properties that depend only on timing and framing. These are the four-cycle luma and valid delay, the strict Cb-then-Cr order on the chroma lane, the rule that a line start never carries Cr, the chroma-less final pixel of odd-length lines, and plain decimation in mode 0. The filter arithmetic of modes 1 to 3 needs a stimulus and an independent model to check against, and so do edge replication at both line ends and the isolation of back-to-back lines. Only the bench's scenarios cover these: lines of length 1, 2 and odd lengths, full-scale alternating values, and lines sent with no gap between them.

// File: rtl/c422_pkg.sv
package c422_pkg;

  // Mode number = {low-pass enable, centred position}
  typedef enum logic [1:0] {
    C422_DECIM = 2'd0,  // pick even sample, cosited
    C422_AVG2  = 2'd1,  // two-tap mean, centred
    C422_TRI   = 2'd2,  // 1-2-1 smoothing, cosited
    C422_QUAD  = 2'd3   // 1-3-3-1 smoothing, centred
  } c422_mode_e;

  function automatic c422_mode_e c422_mode(input logic lpf_en, input logic pos_ctr);
    return c422_mode_e'({lpf_en, pos_ctr});
  endfunction

endpackage

// File: rtl/c422_taps.sv
// Builds the four-tap window for one chroma lane, replicating edge samples
// so that no tap reaches outside the current line.
module c422_taps #(
  parameter int DW = 8
) (
  input  logic          cur_sol,  // current (even) pixel starts a line
  input  logic          nxt_eol,  // its partner ends the line
  input  logic [DW-1:0] s_prv,    // pixel n-1 (may belong to previous line)
  input  logic [DW-1:0] s_cur,    // pixel n
  input  logic [DW-1:0] s_nxt,    // pixel n+1
  input  logic [DW-1:0] s_nx2,    // pixel n+2 (may belong to next line)
  output logic [DW-1:0] t_a,
  output logic [DW-1:0] t_b,
  output logic [DW-1:0] t_c,
  output logic [DW-1:0] t_d
);
  always_comb begin
    t_a = cur_sol ? s_cur : s_prv;
    t_b = s_cur;
    t_c = s_nxt;
    t_d = nxt_eol ? s_nxt : s_nx2;
  end
endmodule

// File: rtl/c422_fir.sv
// Weighted sum, round-to-nearest shift and clip for one chroma lane.
module c422_fir
  import c422_pkg::*;
#(
  parameter int DW = 8
) (
  input  c422_mode_e    mode,
  input  logic [DW-1:0] t_a,
  input  logic [DW-1:0] t_b,
  input  logic [DW-1:0] t_c,
  input  logic [DW-1:0] t_d,
  output logic [DW-1:0] q
);
  localparam int SW = DW + 3;  // room for a weight total of 8
  localparam logic [SW-1:0] RND1 = SW'(1);
  localparam logic [SW-1:0] RND2 = SW'(2);
  localparam logic [SW-1:0] RND4 = SW'(4);
  localparam logic [DW-1:0] MAXV = '1;

  function automatic logic [DW-1:0] clip(input logic [SW-1:0] v);
    if (v > {3'b000, MAXV}) return MAXV;
    return v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] weigh(
    input c422_mode_e m,
    input logic [DW-1:0] a, input logic [DW-1:0] b,
    input logic [DW-1:0] c, input logic [DW-1:0] d);
    logic [SW-1:0] ea, eb, ec, ed, r;
    ea = {3'b000, a};
    eb = {3'b000, b};
    ec = {3'b000, c};
    ed = {3'b000, d};
    case (m)
      C422_DECIM: r = eb;
      C422_AVG2:  r = (eb + ec + RND1) >> 1;
      C422_TRI:   r = (ea + (eb << 1) + ec + RND2) >> 2;
      default:    r = (ea + eb + (eb << 1) + ec + (ec << 1) + ed + RND4) >> 3;
    endcase
    return clip(r);
  endfunction

  always_comb q = weigh(mode, t_a, t_b, t_c, t_d);
endmodule

// File: rtl/c422_downsampler.sv
module c422_downsampler
  import c422_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_lpf_en,
  input  logic          cfg_pos_ctr,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic          in_eol,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cb,
  input  logic [DW-1:0] in_cr,
  output logic          out_valid,
  output logic          out_sol,
  output logic          out_eol,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_c,
  output logic          out_c_valid,
  output logic          out_c_is_cr
);
  // Pixel word layout: {sol, eol, y, cb, cr}
  localparam int CR_LO  = 0;
  localparam int CB_LO  = DW;
  localparam int Y_LO   = 2 * DW;
  localparam int EOL_B  = 3 * DW;
  localparam int SOL_B  = 3 * DW + 1;
  localparam int PW     = 3 * DW + 2;
  localparam int STAGES = 3;            // n+2, n+1, n
  localparam int LANES  = 2;            // 0 = Cb, 1 = Cr

  logic [PW-1:0]     pipe [STAGES];
  logic [STAGES-1:0] pv;
  logic [2*DW-1:0]   prv_c;             // chroma of pixel n-1 {cb, cr}

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv    <= '0;
      prv_c <= '0;
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pv[0]   <= in_valid;
      pipe[0] <= {in_sol, in_eol, in_y, in_cb, in_cr};
      for (int s = 1; s < STAGES; s++) begin
        pv[s]   <= pv[s-1];
        pipe[s] <= pipe[s-1];
      end
      prv_c <= pipe[STAGES-1][CB_LO+DW-1:CR_LO];
    end
  end

  // Decision stage: pixel n sits in the last pipe stage
  logic [PW-1:0] cur_w, nxt_w, nx2_w;
  logic          cur_v, cur_sol, cur_eol, nxt_eol;
  logic          prev_even_q, is_even, has_pair;
  logic          pair_start, unpaired_pix;
  c422_mode_e    mode;

  always_comb begin
    cur_w        = pipe[2];
    nxt_w        = pipe[1];
    nx2_w        = pipe[0];
    cur_v        = pv[2];
    cur_sol      = cur_w[SOL_B];
    cur_eol      = cur_w[EOL_B];
    nxt_eol      = nxt_w[EOL_B];
    mode         = c422_mode(cfg_lpf_en, cfg_pos_ctr);
    is_even      = cur_sol | ~prev_even_q;
    has_pair     = ~cur_eol;
    pair_start   = cur_v & is_even & has_pair;
    unpaired_pix = cur_v & is_even & cur_eol;
  end

  logic [DW-1:0] filt [LANES];

  for (genvar ch = 0; ch < LANES; ch++) begin : g_lane
    localparam int LO = (ch == 0) ? CB_LO : CR_LO;
    localparam int PO = (ch == 0) ? DW : 0;
    logic [DW-1:0] ta, tb, tc, td;

    c422_taps #(.DW(DW)) u_taps (
      .cur_sol (cur_sol),
      .nxt_eol (nxt_eol),
      .s_prv   (prv_c[PO+DW-1:PO]),
      .s_cur   (cur_w[LO+DW-1:LO]),
      .s_nxt   (nxt_w[LO+DW-1:LO]),
      .s_nx2   (nx2_w[LO+DW-1:LO]),
      .t_a     (ta),
      .t_b     (tb),
      .t_c     (tc),
      .t_d     (td)
    );

    c422_fir #(.DW(DW)) u_fir (
      .mode (mode),
      .t_a  (ta),
      .t_b  (tb),
      .t_c  (tc),
      .t_d  (td),
      .q    (filt[ch])
    );
  end

  logic [DW-1:0] cr_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sol     <= 1'b0;
      out_eol     <= 1'b0;
      out_y       <= '0;
      out_c       <= '0;
      out_c_valid <= 1'b0;
      out_c_is_cr <= 1'b0;
      cr_hold     <= '0;
      prev_even_q <= 1'b0;
    end else begin
      out_valid <= cur_v;
      if (cur_v) begin
        out_y       <= cur_w[Y_LO+DW-1:Y_LO];
        out_sol     <= cur_sol;
        out_eol     <= cur_eol;
        prev_even_q <= is_even;
        if (pair_start) begin
          out_c       <= filt[0];
          out_c_valid <= 1'b1;
          out_c_is_cr <= 1'b0;
          cr_hold     <= filt[1];
        end else if (unpaired_pix) begin
          out_c       <= '0;
          out_c_valid <= 1'b0;
          out_c_is_cr <= 1'b0;
        end else begin
          out_c       <= cr_hold;
          out_c_valid <= 1'b1;
          out_c_is_cr <= 1'b1;
        end
      end else begin
        out_c_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/c422_checker.sv
module c422_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_lpf_en,
  input logic          cfg_pos_ctr,
  input logic          in_valid,
  input logic [DW-1:0] in_y,
  input logic [DW-1:0] in_cb,
  input logic          out_valid,
  input logic          out_sol,
  input logic          out_eol,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_c,
  input logic          out_c_valid,
  input logic          out_c_is_cr,
  input logic          pair_start,
  input logic          unpaired_pix
);
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4)); // R1

  AST_LUMA_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_y == $past(in_y, 4)); // R1

  AST_CHROMA_NEEDS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    out_c_valid |-> out_valid); // R2

  AST_CB_THEN_CR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_c_valid && !out_c_is_cr) |=> (out_valid && out_c_valid && out_c_is_cr)); // R2

  AST_CR_AFTER_CB: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_c_valid && out_c_is_cr) |-> $past(out_valid && out_c_valid && !out_c_is_cr)); // R2

  AST_SOL_NOT_CR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sol) |-> !out_c_is_cr); // R2

  AST_PAIR_START_CB: assert property (@(posedge clk) disable iff (!rst_n)
    pair_start |=> (out_valid && out_c_valid && !out_c_is_cr)); // R2

  AST_DECIM_CB: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_c_valid && !out_c_is_cr && !cfg_lpf_en && !cfg_pos_ctr)
      |-> out_c == $past(in_cb, 4)); // R3

  AST_UNPAIRED_AT_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    unpaired_pix |=> (out_valid && out_eol && !out_c_valid && out_c == '0)); // R8

  AST_NO_CHROMA_ONLY_AT_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_c_valid) |-> out_eol); // R8
endmodule

bind c422_downsampler c422_checker #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_lpf_en   (cfg_lpf_en),
  .cfg_pos_ctr  (cfg_pos_ctr),
  .in_valid     (in_valid),
  .in_y         (in_y),
  .in_cb        (in_cb),
  .out_valid    (out_valid),
  .out_sol      (out_sol),
  .out_eol      (out_eol),
  .out_y        (out_y),
  .out_c        (out_c),
  .out_c_valid  (out_c_valid),
  .out_c_is_cr  (out_c_is_cr),
  .pair_start   (pair_start),
  .unpaired_pix (unpaired_pix)
);

// File: tb/tb_c422_downsampler.sv
module tb_c422_downsampler;
  localparam int DW     = 8;
  localparam int MAXLEN = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_lpf_en = 1'b0, cfg_pos_ctr = 1'b0;
  logic          in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [DW-1:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic          out_valid, out_sol, out_eol, out_c_valid, out_c_is_cr;
  logic [DW-1:0] out_y, out_c;

  always #4 clk = ~clk;  // 125 MHz

  c422_downsampler #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_lpf_en(cfg_lpf_en), .cfg_pos_ctr(cfg_pos_ctr),
    .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol), .out_y(out_y),
    .out_c(out_c), .out_c_valid(out_c_valid), .out_c_is_cr(out_c_is_cr)
  );

  typedef struct {
    int    y;
    bit    sol;
    bit    eol;
    bit    cv;
    bit    icr;
    int    c;
    int    mode;
    string tag;
  } exp_t;

  exp_t  expq[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  int    lum [MAXLEN];
  int    cbl [MAXLEN];
  int    crl [MAXLEN];

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Sample with index clamped to the line (edge replication)
  function automatic int smp(input bit is_cr, input int i, input int n);
    int j;
    j = (i < 0) ? 0 : ((i >= n) ? n - 1 : i);
    return is_cr ? crl[j] : cbl[j];
  endfunction

  function automatic int ref_chroma(input int mode, input bit is_cr, input int k, input int n);
    int p, q, r, s, v;
    p = smp(is_cr, 2*k - 1, n);
    q = smp(is_cr, 2*k,     n);
    r = smp(is_cr, 2*k + 1, n);
    s = smp(is_cr, 2*k + 2, n);
    case (mode)
      0:       v = q;
      1:       v = (q + r + 1) / 2;
      2:       v = (p + 2*q + r + 2) / 4;
      default: v = (p + 3*q + 3*r + s + 4) / 8;
    endcase
    return (v > 255) ? 255 : v;
  endfunction

  // kind 0: smooth-ish varied pattern, kind 1: full-scale alternation
  task automatic send_line(input int n, input int seed, input int kind, input string tag);
    int   mode;
    exp_t e;
    mode = {cfg_lpf_en, cfg_pos_ctr};
    for (int i = 0; i < n; i++) begin
      lum[i] = (seed * 17 + i * 41) % 256;
      if (kind == 1) begin
        cbl[i] = (i % 3 == 0) ? 0 : 255;
        crl[i] = 255 - cbl[i];
      end else begin
        cbl[i] = (seed * 29 + i * 71 + i * i * 13) % 256;
        crl[i] = (seed * 53 + i * 19 + i * i * 37 + 100) % 256;
      end
    end
    for (int i = 0; i < n; i++) begin
      e.y = lum[i]; e.sol = (i == 0); e.eol = (i == n - 1);
      e.mode = mode; e.tag = tag;
      if (i % 2 == 0) begin
        e.icr = 1'b0;
        if (i + 1 < n) begin e.cv = 1'b1; e.c = ref_chroma(mode, 1'b0, i / 2, n); end
        else           begin e.cv = 1'b0; e.c = 0; end
      end else begin
        e.icr = 1'b1; e.cv = 1'b1; e.c = ref_chroma(mode, 1'b1, i / 2, n);
      end
      expq.push_back(e);
    end
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_sol = (i == 0); in_eol = (i == n - 1);
      in_y = DW'(lum[i]); in_cb = DW'(cbl[i]); in_cr = DW'(crl[i]);
    end
  endtask

  task automatic idle(input int cycles);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input bit lpf, input bit ctr);
    idle(8);
    cfg_lpf_en = lpf; cfg_pos_ctr = ctr;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R1", 1, 0, "unexpected output pixel");
      end else begin
        exp_t e;
        string creq;
        e = expq.pop_front();
        check(out_y == DW'(e.y), "R1", out_y, e.y, {"luma ", e.tag});
        check(out_sol == e.sol && out_eol == e.eol, "R1", {out_sol, out_eol}, {e.sol, e.eol},
              {"line flags ", e.tag});
        check(out_c_is_cr == e.icr, "R2", out_c_is_cr, e.icr, {"chroma lane order ", e.tag});
        if (!e.cv)          creq = "R8";
        else if (e.mode==0) creq = "R3";
        else if (e.mode==1) creq = "R4";
        else if (e.mode==2) creq = "R5";
        else                creq = "R6";
        check(out_c_valid == e.cv, creq, out_c_valid, e.cv, {"chroma valid ", e.tag});
        check(out_c == DW'(e.c), creq, out_c, e.c, {"chroma value ", e.tag});
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && out_c_valid == 1'b0, "R1", {out_valid, out_c_valid}, 0, "outputs idle in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0, "idle after reset");

    set_mode(1'b0, 1'b0);
    send_line(8, 1, 0, "R3 R9 decimation");
    send_line(3, 2, 0, "R3 R8 odd short line");
    set_mode(1'b0, 1'b1);
    send_line(8, 3, 0, "R4 R9 pair mean");
    send_line(16, 4, 1, "R4 full-scale");
    set_mode(1'b1, 1'b0);
    send_line(10, 5, 0, "R5 R7 tri edges");
    send_line(7, 6, 0, "R5 R8 odd line");
    send_line(2, 7, 0, "R5 R7 two-pixel line");
    set_mode(1'b1, 1'b1);
    send_line(12, 8, 0, "R6 R7 quad edges");
    send_line(2, 9, 0, "R6 R7 two-pixel line");
    send_line(1, 10, 0, "R8 R7 single pixel");
    idle(3);
    send_line(6, 11, 0, "R10 back-to-back first");
    send_line(5, 12, 0, "R10 R8 back-to-back second");
    send_line(9, 13, 1, "R6 R9 clip full-scale");
    idle(12);

    @(negedge clk);
    check(expq.size() == 0, "R1", expq.size(), 0, "all pixels delivered");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule